// File: doc/BRIEF.md
# Non-Blocking Miss Tracker

This block keeps track of outstanding misses for a non-blocking L1 data cache. It holds a small pool of fill-buffer entries. Each entry tracks one 64-byte line. Every cycle, each lookup port presents a load or store with its line address, a doubleword offset, the cache tag-hit result and a memory-type attribute. In the same cycle the block answers with a grant and an outcome: a hit that may proceed, a merge into an entry already in flight, a new entry, or a pass-through that needs no entry. A port whose request cannot be taken in that cycle sees its grant low and presents the request again.

The pool is shared between cacheable line fills and non-cacheable reads. Waiting entries are offered to a downstream memory port one at a time, using a valid/ready handshake. Fill data comes back in four beats, and each beat is tagged with an entry index. After the last beat the entry raises a one-cycle completion that names the line. The completion tells the cache whether to write the line into its arrays and whether merged accesses must replay. For a non-cacheable read, the completion also carries the requested doubleword. A flush drops every entry that has not yet been handed downstream.

Top module: `miss_tracker`

## Requirements
- R1: No more than six entries (NE) are busy at a time. A request that needs a new entry while none is free gets grant 0 and kind ALLOC.
- R2: A lookup with `lk_hit_i`=1 and attribute 0..3 (to a line not held by a busy entry) is granted in the same cycle with kind HIT (0). This holds for loads and stores, whatever misses are pending.
- R3: Attribute encoding: 0 = write-back read/write-allocate, 1 = write-back no-allocate, 2 = write-through, 3 = non-cacheable, 4..7 = device or strongly-ordered. Handling by attribute:
  - Attribute 0: a miss allocates a line entry.
  - Any other attribute: a load allocates a non-cacheable entry when it misses, or always when the attribute is 4..7.
  - A store that is neither a hit nor an attribute-0 miss is granted with kind PASS (3).
  - Kind ALLOC is 2.
- R4: A lookup to a line held by a waiting or issued entry is granted with kind MERGE (1) and that entry's index, and takes no new entry. That entry's completion then shows `done_replay_o`=1. A match on a completing entry gets grant 0.
- R5: When several ports need a new entry in one cycle, only the lowest-numbered of them may be granted. It receives the lowest-numbered free entry, and the others get grant 0.
- R6: `mem_req_*` presents the lowest-numbered waiting entry. A request left unaccepted keeps the same index until `mem_req_ready_i` takes it. The entry then counts as issued.
- R7: On the edge that takes the fourth fill beat of an issued entry, the entry starts a single-cycle `done_valid_o` pulse that carries its index and line. On the next edge the entry is free, and a lookup to that line may allocate again.
- R8: `done_write_o` is 1 for attribute-0 entries and 0 for non-cacheable entries. For a non-cacheable entry, `done_data_o` is the doubleword at offset `lk_off_i`: beat = offset[2:1], upper 64 bits when offset[0]=1.
- R9: While `flush_i` is high, `mem_req_valid_o` is 0, no new entry is granted, and merges into waiting entries get grant 0. On the next edge every waiting entry becomes free, while issued entries run to completion.
- R10: A fill beat whose index names an entry that is not issued is ignored.
- R11: After reset all entries are free, and `mem_req_valid_o` and `done_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all entries not yet issued |
| lk_valid_i | input | NP | Lookup present, one bit per port |
| lk_store_i | input | NP | 1 = store, 0 = load |
| lk_hit_i | input | NP | Tag hit from the cache |
| lk_attr_i | input | NP x 3 | Memory-type attribute per port |
| lk_line_i | input | NP x LINE_W | Line address per port |
| lk_off_i | input | NP x 3 | Doubleword offset within the line |
| lk_grant_o | output | NP | Lookup accepted this cycle |
| lk_kind_o | output | NP x 2 | Outcome: 0 hit, 1 merge, 2 alloc, 3 pass |
| lk_idx_o | output | NP x IDX_W | Entry index for merge or alloc |
| mem_req_valid_o | output | 1 | Downstream fill request valid |
| mem_req_ready_i | input | 1 | Downstream accepts request |
| mem_req_idx_o | output | IDX_W | Entry index of the request |
| mem_req_line_o | output | LINE_W | Line address of the request |
| mem_req_nc_o | output | 1 | Request is a non-cacheable read |
| fill_valid_i | input | 1 | Fill beat present |
| fill_idx_i | input | IDX_W | Entry index of the beat |
| fill_data_i | input | BEAT_W | Beat payload |
| done_valid_o | output | 1 | Entry completion pulse |
| done_idx_o | output | IDX_W | Completing entry |
| done_line_o | output | LINE_W | Completing line |
| done_write_o | output | 1 | Write line into cache arrays |
| done_replay_o | output | 1 | Merged accesses must replay |
| done_data_o | output | 64 | Requested doubleword of a non-cacheable read |

## Verification
Two collisions get the most attention. The first is a completion pulse falling in the same cycle as a new lookup to the line that is completing. The bench expects grant 0 in that cycle and a fresh allocation one cycle later. The second is a flush arriving while a request is being presented, together with merges into waiting entries. Both are provoked by directed sequences, and then again by seeded random traffic over a small set of line addresses with random ready, fill and flush timing. A cycle-by-cycle reference model in the bench predicts every grant, kind, index, request and completion field, and each observed value is compared against it.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {E_FREE, E_WAIT, E_ISSUED, E_DONE} ent_st_e;
  typedef enum logic [1:0] {K_HIT = 2'd0, K_MERGE = 2'd1, K_ALLOC = 2'd2, K_PASS = 2'd3} lk_kind_e;
  localparam logic [2:0] ATTR_ALLOC = 3'd0;  // write-back read/write-allocate
  localparam logic [2:0] ATTR_BYPASS = 3'd4; // this value and above: device class
endpackage

// File: rtl/mt_pick.sv
module mt_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mt_classify.sv
module mt_classify import mt_pkg::*; (
  input  logic       store_i,
  input  logic       hit_i,
  input  logic [2:0] attr_i,
  output logic       hit_ok_o,
  output logic       need_o,
  output logic       nc_o
);
  logic alloc_attr, bypass;
  assign alloc_attr = (attr_i == ATTR_ALLOC);
  assign bypass     = (attr_i >= ATTR_BYPASS);
  assign hit_ok_o   = hit_i && !bypass;
  assign need_o     = alloc_attr ? !hit_i : (!store_i && !hit_ok_o);
  assign nc_o       = !alloc_attr;
endmodule

// File: rtl/mt_entry.sv
module mt_entry import mt_pkg::*; #(
  parameter int LINE_W = 26,
  parameter int BEAT_W = 128,
  parameter int NBEATS = 4,
  parameter int OFF_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              alloc_nc_i,
  input  logic [OFF_W-1:0]  alloc_off_i,
  input  logic              merge_i,
  input  logic              issue_i,
  input  logic              flush_i,
  input  logic              beat_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  output ent_st_e           st_o,
  output logic [LINE_W-1:0] line_o,
  output logic              nc_o,
  output logic              pend_o,
  output logic [63:0]       data_o
);
  localparam int CW    = $clog2(NBEATS);
  localparam int DPB   = BEAT_W / 64;
  localparam int SEL_W = $clog2(DPB);

  ent_st_e           st_q;
  logic [LINE_W-1:0] line_q;
  logic              nc_q, pend_q;
  logic [OFF_W-1:0]  off_q;
  logic [CW-1:0]     cnt_q;
  logic [63:0]       data_q;
  logic [CW-1:0]     want_beat;
  logic [63:0]       want_dw;

  assign want_beat = CW'(off_q >> SEL_W);
  assign want_dw   = beat_data_i[64*int'(off_q[SEL_W-1:0]) +: 64];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_FREE;
      line_q <= '0;
      nc_q   <= 1'b0;
      pend_q <= 1'b0;
      off_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        E_FREE: if (alloc_i) begin
          st_q   <= E_WAIT;
          line_q <= alloc_line_i;
          nc_q   <= alloc_nc_i;
          off_q  <= alloc_off_i;
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end
        E_WAIT: begin
          if (flush_i)      st_q <= E_FREE;
          else if (issue_i) st_q <= E_ISSUED;
        end
        E_ISSUED: if (beat_i) begin
          if (nc_q && cnt_q == want_beat) data_q <= want_dw;
          if (cnt_q == CW'(NBEATS - 1)) begin
            st_q  <= E_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= E_FREE;
      endcase
      if (merge_i) pend_q <= 1'b1;
    end
  end

  assign st_o   = st_q;
  assign line_o = line_q;
  assign nc_o   = nc_q;
  assign pend_o = pend_q;
  assign data_o = data_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == E_DONE |=> st_q == E_FREE); // R7
  AST_IDLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && st_q != E_ISSUED) |=> ($stable(cnt_q) && $stable(data_q))); // R10
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker import mt_pkg::*; #(
  parameter int NE     = 6,
  parameter int NP     = 2,
  parameter int LINE_W = 26,
  parameter int BEAT_W = 128,
  parameter int NBEATS = 4,
  parameter int IDX_W  = $clog2(NE)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [NP-1:0]                lk_valid_i,
  input  logic [NP-1:0]                lk_store_i,
  input  logic [NP-1:0]                lk_hit_i,
  input  logic [NP-1:0][2:0]           lk_attr_i,
  input  logic [NP-1:0][LINE_W-1:0]    lk_line_i,
  input  logic [NP-1:0][2:0]           lk_off_i,
  output logic [NP-1:0]                lk_grant_o,
  output logic [NP-1:0][1:0]           lk_kind_o,
  output logic [NP-1:0][IDX_W-1:0]     lk_idx_o,
  output logic                         mem_req_valid_o,
  input  logic                         mem_req_ready_i,
  output logic [IDX_W-1:0]             mem_req_idx_o,
  output logic [LINE_W-1:0]            mem_req_line_o,
  output logic                         mem_req_nc_o,
  input  logic                         fill_valid_i,
  input  logic [IDX_W-1:0]             fill_idx_i,
  input  logic [BEAT_W-1:0]            fill_data_i,
  output logic                         done_valid_o,
  output logic [IDX_W-1:0]             done_idx_o,
  output logic [LINE_W-1:0]            done_line_o,
  output logic                         done_write_o,
  output logic                         done_replay_o,
  output logic [63:0]                  done_data_o
);
  ent_st_e           ent_st   [NE];
  logic [LINE_W-1:0] ent_line [NE];
  logic              ent_nc   [NE];
  logic              ent_pend [NE];
  logic [63:0]       ent_data [NE];

  logic [NE-1:0] free_vec, wait_vec, done_vec, alloc_vec, merge_vec, issue_vec, beat_vec;
  logic              free_found, wait_found;
  logic [IDX_W-1:0]  free_idx, wait_idx, sel_idx;
  logic [LINE_W-1:0] a_line;
  logic              a_nc;
  logic [2:0]        a_off;
  logic              hold_q;
  logic [IDX_W-1:0]  hold_idx_q;

  logic [NP-1:0][NE-1:0]    match;
  logic [NP-1:0]            mhit, hit_ok, need, nc_p;
  logic [NP-1:0][IDX_W-1:0] midx;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    assign free_vec[e]  = (ent_st[e] == E_FREE);
    assign wait_vec[e]  = (ent_st[e] == E_WAIT);
    assign done_vec[e]  = (ent_st[e] == E_DONE);
    assign issue_vec[e] = mem_req_valid_o && mem_req_ready_i && (sel_idx == IDX_W'(e));
    assign beat_vec[e]  = fill_valid_i && (fill_idx_i == IDX_W'(e));
    mt_entry #(.LINE_W(LINE_W), .BEAT_W(BEAT_W), .NBEATS(NBEATS), .OFF_W(3)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(alloc_vec[e]), .alloc_line_i(a_line), .alloc_nc_i(a_nc), .alloc_off_i(a_off),
      .merge_i(merge_vec[e]), .issue_i(issue_vec[e]), .flush_i,
      .beat_i(beat_vec[e]), .beat_data_i(fill_data_i),
      .st_o(ent_st[e]), .line_o(ent_line[e]), .nc_o(ent_nc[e]),
      .pend_o(ent_pend[e]), .data_o(ent_data[e]));
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar e = 0; e < NE; e++) begin : g_m
      assign match[p][e] = !free_vec[e] && (ent_line[e] == lk_line_i[p]);
    end
    mt_pick #(.N(NE), .IW(IDX_W)) u_mpick (.vec_i(match[p]), .found_o(mhit[p]), .idx_o(midx[p]));
    mt_classify u_cls (.store_i(lk_store_i[p]), .hit_i(lk_hit_i[p]), .attr_i(lk_attr_i[p]),
                       .hit_ok_o(hit_ok[p]), .need_o(need[p]), .nc_o(nc_p[p]));
  end

  mt_pick #(.N(NE), .IW(IDX_W)) u_free (.vec_i(free_vec), .found_o(free_found), .idx_o(free_idx));
  mt_pick #(.N(NE), .IW(IDX_W)) u_wait (.vec_i(wait_vec), .found_o(wait_found), .idx_o(wait_idx));

  always_comb begin
    logic lower_need;
    lower_need = 1'b0;
    alloc_vec  = '0;
    merge_vec  = '0;
    a_line     = '0;
    a_nc       = 1'b0;
    a_off      = '0;
    for (int p = 0; p < NP; p++) begin
      lk_grant_o[p] = 1'b0;
      lk_kind_o[p]  = K_PASS;
      lk_idx_o[p]   = '0;
      if (lk_valid_i[p]) begin
        if (mhit[p]) begin
          lk_kind_o[p]  = K_MERGE;
          lk_idx_o[p]   = midx[p];
          lk_grant_o[p] = !(ent_st[midx[p]] == E_DONE || (ent_st[midx[p]] == E_WAIT && flush_i));
          if (lk_grant_o[p]) merge_vec[midx[p]] = 1'b1;
        end else if (hit_ok[p]) begin
          lk_kind_o[p]  = K_HIT;
          lk_grant_o[p] = 1'b1;
        end else if (need[p]) begin
          lk_kind_o[p]  = K_ALLOC;
          lk_idx_o[p]   = free_idx;
          lk_grant_o[p] = !lower_need && free_found && !flush_i;
          lower_need    = 1'b1;
          if (lk_grant_o[p]) begin
            alloc_vec[free_idx] = 1'b1;
            a_line = lk_line_i[p];
            a_nc   = nc_p[p];
            a_off  = lk_off_i[p];
          end
        end else begin
          lk_grant_o[p] = 1'b1;
        end
      end
    end
  end

  // held request keeps its index until accepted
  assign sel_idx         = hold_q ? hold_idx_q : wait_idx;
  assign mem_req_valid_o = (hold_q || wait_found) && !flush_i;
  assign mem_req_idx_o   = sel_idx;
  assign mem_req_line_o  = ent_line[sel_idx];
  assign mem_req_nc_o    = ent_nc[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= mem_req_valid_o && !mem_req_ready_i;
      hold_idx_q <= sel_idx;
    end
  end

  mt_pick #(.N(NE), .IW(IDX_W)) u_done (.vec_i(done_vec), .found_o(done_valid_o), .idx_o(done_idx_o));
  assign done_line_o   = ent_line[done_idx_o];
  assign done_write_o  = !ent_nc[done_idx_o];
  assign done_replay_o = ent_pend[done_idx_o];
  assign done_data_o   = ent_data[done_idx_o];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_vec == '0) |-> (alloc_vec == '0)); // R1
  AST_ONE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(alloc_vec) <= 1); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> $stable(mem_req_idx_o)); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!mem_req_valid_o && alloc_vec == '0)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_vec)); // R7
endmodule

// File: tb/miss_tracker_tb.sv
module miss_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 6, NP = 2, LW = 26, BW = 128, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              flush = 0, ready = 0, fv = 0;
  logic [NP-1:0]     v = '0, st = '0, hit = '0;
  logic [NP-1:0][2:0]    attr = '0, off = '0;
  logic [NP-1:0][LW-1:0] line = '0;
  logic [IW-1:0]     fidx = '0;
  logic [BW-1:0]     fdata = '0;

  logic [NP-1:0]         grant;
  logic [NP-1:0][1:0]    kind;
  logic [NP-1:0][IW-1:0] gidx;
  logic req_v, req_nc, d_v, d_w, d_r;
  logic [IW-1:0] req_idx, d_idx;
  logic [LW-1:0] req_line, d_line;
  logic [63:0] d_data;

  miss_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_valid_i(v), .lk_store_i(st), .lk_hit_i(hit), .lk_attr_i(attr), .lk_line_i(line), .lk_off_i(off),
    .lk_grant_o(grant), .lk_kind_o(kind), .lk_idx_o(gidx),
    .mem_req_valid_o(req_v), .mem_req_ready_i(ready), .mem_req_idx_o(req_idx),
    .mem_req_line_o(req_line), .mem_req_nc_o(req_nc),
    .fill_valid_i(fv), .fill_idx_i(fidx), .fill_data_i(fdata),
    .done_valid_o(d_v), .done_idx_o(d_idx), .done_line_o(d_line), .done_write_o(d_w),
    .done_replay_o(d_r), .done_data_o(d_data));

  int checks = 0, errs = 0;
  bit finished = 0;

  // reference model: state 0 free, 1 waiting, 2 issued, 3 completing
  int m_st[NE], m_cnt[NE];
  logic [LW-1:0] m_line[NE];
  bit m_nc[NE], m_pend[NE];
  bit [2:0] m_off[NE];
  logic [63:0] m_data[NE];
  bit m_hold; int m_hidx;
  bit e_grant[NP]; int e_kind[NP], e_idx[NP];
  bit e_req_v; int e_req_idx, e_done;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    int fi = -1, wi = -1; bit lower = 0;
    for (int e = 0; e < NE; e++) begin
      if (m_st[e] == 0 && fi < 0) fi = e;
      if (m_st[e] == 1 && wi < 0) wi = e;
    end
    for (int p = 0; p < NP; p++) begin
      int mi = -1; bit hok, need;
      e_grant[p] = 0; e_kind[p] = 3; e_idx[p] = 0;
      if (!v[p]) continue;
      for (int e = 0; e < NE; e++) if (m_st[e] != 0 && m_line[e] == line[p]) mi = e;
      hok  = hit[p] && attr[p] < 4;
      need = (attr[p] == 0) ? !hit[p] : (!st[p] && !hok);
      if (mi >= 0) begin
        e_kind[p] = 1; e_idx[p] = mi;
        e_grant[p] = !(m_st[mi] == 3 || (m_st[mi] == 1 && flush));
      end else if (hok) begin
        e_kind[p] = 0; e_grant[p] = 1;
      end else if (need) begin
        e_kind[p] = 2; e_idx[p] = fi;
        e_grant[p] = !lower && fi >= 0 && !flush;
        lower = 1;
      end else e_grant[p] = 1;
    end
    e_req_v = (m_hold || wi >= 0) && !flush;
    e_req_idx = m_hold ? m_hidx : wi;
    e_done = -1;
    for (int e = 0; e < NE; e++) if (m_st[e] == 3) e_done = e;
  endtask

  function automatic string ktag(int p);
    if (flush && e_kind[p] != 0 && e_kind[p] != 3) return "R9";
    case (e_kind[p])
      0: return "R2";
      1: return "R4";
      2: begin
        bit anyf = 0;
        for (int e = 0; e < NE; e++) if (m_st[e] == 0) anyf = 1;
        if (!anyf) return "R1";
        return (p > 0 && !e_grant[p]) ? "R5" : "R3";
      end
      default: return "R3";
    endcase
  endfunction

  task automatic compare();
    for (int p = 0; p < NP; p++) if (v[p]) begin
      chk(grant[p] == e_grant[p], ktag(p), grant[p], e_grant[p]);
      chk(kind[p] == e_kind[p][1:0], ktag(p), kind[p], e_kind[p]);
      if (e_grant[p] && (e_kind[p] == 1 || e_kind[p] == 2))
        chk(gidx[p] == e_idx[p][IW-1:0], ktag(p), gidx[p], e_idx[p]);
    end
    chk(req_v == e_req_v, flush ? "R9" : "R6", req_v, e_req_v);
    if (e_req_v) begin
      chk(req_idx == e_req_idx[IW-1:0], "R6", req_idx, e_req_idx);
      chk(req_line == m_line[e_req_idx], "R6", req_line, m_line[e_req_idx]);
      chk(req_nc == m_nc[e_req_idx], "R6", req_nc, m_nc[e_req_idx]);
    end
    chk(d_v == (e_done >= 0), "R7", d_v, e_done >= 0);
    if (e_done >= 0) begin
      chk(d_idx == e_done[IW-1:0], "R7", d_idx, e_done);
      chk(d_line == m_line[e_done], "R7", d_line, m_line[e_done]);
      chk(d_w == !m_nc[e_done], "R8", d_w, !m_nc[e_done]);
      chk(d_r == m_pend[e_done], "R4", d_r, m_pend[e_done]);
      if (m_nc[e_done]) chk(d_data == m_data[e_done], "R8", d_data, m_data[e_done]);
    end
  endtask

  task automatic update();
    int old[NE];
    for (int e = 0; e < NE; e++) old[e] = m_st[e];
    for (int e = 0; e < NE; e++) begin
      case (old[e])
        3: m_st[e] = 0;
        1: if (flush) m_st[e] = 0;
           else if (e_req_v && ready && e_req_idx == e) m_st[e] = 2;
        2: if (fv && fidx == e) begin
             if (m_nc[e] && m_cnt[e] == int'(m_off[e] >> 1))
               m_data[e] = m_off[e][0] ? fdata[127:64] : fdata[63:0];
             m_cnt[e]++;
             if (m_cnt[e] == 4) begin m_st[e] = 3; m_cnt[e] = 0; end
           end
        default: ;
      endcase
    end
    for (int p = 0; p < NP; p++) if (v[p] && e_grant[p]) begin
      if (e_kind[p] == 1) m_pend[e_idx[p]] = 1;
      if (e_kind[p] == 2) begin
        m_st[e_idx[p]] = 1; m_line[e_idx[p]] = line[p]; m_nc[e_idx[p]] = attr[p] != 0;
        m_off[e_idx[p]] = off[p]; m_pend[e_idx[p]] = 0; m_cnt[e_idx[p]] = 0;
      end
    end
    m_hold = e_req_v && !ready;
    m_hidx = e_req_idx;
  endtask

  task automatic step();
    @(negedge clk);
    predict();
    compare();
    @(posedge clk);
    update();
    #1;
  endtask

  task automatic idle();
    v = '0; flush = 0; fv = 0;
  endtask

  task automatic look(int p, bit s, bit h, int a, int ln, int o);
    v[p] = 1; st[p] = s; hit[p] = h; attr[p] = 3'(a); line[p] = LW'(ln); off[p] = 3'(o);
  endtask

  task automatic beats(int idx, int n);
    for (int i = 0; i < n; i++) begin
      fv = 1; fidx = IW'(idx);
      fdata = {$urandom, $urandom, $urandom, $urandom};
      step();
    end
    fv = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int e = 0; e < NE; e++) begin
      m_st[e] = 0; m_cnt[e] = 0; m_line[e] = '0; m_nc[e] = 0; m_pend[e] = 0; m_off[e] = 0; m_data[e] = '0;
    end
    m_hold = 0; m_hidx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_v == 0, "R11", req_v, 0);      // R11 reset state
    chk(d_v == 0, "R11", d_v, 0);
    @(posedge clk); #1;

    // R1: fill all six entries, seventh stalls
    for (int i = 0; i < NE; i++) begin idle(); look(0, 0, 0, 0, 100 + i, 0); step(); end
    idle(); look(0, 0, 0, 0, 150, 0); step();
    // R2: hits to other lines go ahead, load and store
    idle(); look(0, 0, 1, 0, 200, 0); look(1, 1, 1, 2, 201, 0); step();
    // R4: merge into busy entry 1
    idle(); look(1, 1, 0, 0, 101, 0); step();
    // R6: issue entries, holding one cycle first
    idle(); step();
    ready = 1; step(); step(); ready = 0;
    // R10: beats to a still waiting entry (entry 2) are ignored
    idle(); beats(2, 4);
    chk(d_v == 0, "R10", d_v, 0);
    // R7: complete entry 1 (merged), then same-line lookup during pulse
    beats(1, 4);
    idle(); look(0, 0, 0, 0, 101, 0); step();  // completion cycle: stall
    idle(); look(0, 0, 0, 0, 101, 0); step();  // now allocates
    // R9: flush drops waiting entries, issued entry 0 completes
    idle(); flush = 1; look(1, 0, 0, 0, 103, 0); step();
    idle(); beats(0, 4); idle(); step();
    // R3/R8: non-cacheable and device reads, offset 5 and 2
    idle(); look(0, 0, 0, 3, 300, 5); step();
    idle(); look(0, 0, 1, 4, 301, 2); look(1, 1, 0, 1, 302, 0); step();
    ready = 1; idle(); repeat (4) step(); ready = 0;
    for (int e = 0; e < NE; e++) if (m_st[e] == 2) beats(e, 4);
    idle(); step(); step();
    // R5: two ports needing entries in one cycle
    idle(); look(0, 0, 0, 0, 400, 0); look(1, 0, 0, 0, 401, 0); step();
    idle(); look(1, 0, 0, 0, 401, 0); step();

    // seeded random traffic
    for (int c = 0; c < 4000; c++) begin
      int iss[$];
      idle();
      for (int p = 0; p < NP; p++)
        if ($urandom % 3 != 0)
          look(p, $urandom % 2, $urandom % 4 == 0, $urandom % 6, 100 + $urandom % 10, $urandom % 8);
      flush = ($urandom % 30 == 0);
      ready = ($urandom % 5 < 3);
      for (int e = 0; e < NE; e++) if (m_st[e] == 2) iss.push_back(e);
      fv = ($urandom % 3 != 0);
      if (iss.size() > 0 && $urandom % 8 != 0) fidx = IW'(iss[$urandom % iss.size()]);
      else fidx = IW'($urandom % 8);
      fdata = {$urandom, $urandom, $urandom, $urandom};
      step();
    end
    idle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule